// File: doc/BRIEF.md
# Octal DDR Pseudo-SRAM Transaction Engine

This block runs one access to an external pseudo-SRAM over an eight-line, double-data-rate bus. A request gives an operation, a 32-bit address, a pair count and write data. The engine then lowers chip select and clocks out a two-byte opcode and four address bytes. It inserts a dummy gap whose length depends on the direction, then moves the data bytes. It closes with chip select high for one slot before it accepts the next request.

Each byte on the bus occupies one slot of `CLK_DIV` system clocks. The byte is launched at the start of its slot and the memory clock toggles in the middle of the slot, so every slot carries exactly one memory-clock edge. Read bytes are sampled on the last system clock of their slot. Array accesses move 2×(pair count + 1) bytes. Register accesses always move two bytes, and the register index travels in the low address bits. A one-cycle `rsp_done` pulse marks the end of every access, and it also marks read data as valid.

Top module: `opsram_xact`

## Requirements
- R1: After reset, chip select is high, the memory clock is low, the bus is not driven, `rsp_done` is low, `rsp_rdata` is zero and `req_ready` is high.
- R2: Each access starts with one lead slot with chip select low and no clock edge. Then come two opcode slots, each carrying the same byte: 0x00 for array read (op 2'b00), 0x80 for array write (op 2'b01), 0x40 for register read (op 2'b10) and 0xC0 for register write (op 2'b11).
- R3: After the opcode, the address is sent in four slots, most significant byte first.
- R4: After the address come exactly `RD_DUMMY` dummy slots for a read (18 by default) and `WR_DUMMY` dummy slots for a write (8 by default).
- R5: On reads, the bus is released from the end of the address through the end of the data. On writes, the bus stays driven with 0x00 through the dummy slots.
- R6: An array access moves 2×(`req_plen`+1) bytes. Write byte j is `req_wdata[8j+7:8j]` and is sent in data slot j.
- R7: Register accesses move two bytes, and `req_plen` has no effect on them.
- R8: Read byte j, sampled in data slot j, appears at `rsp_rdata[8j+7:8j]`. Bytes that are not read are zero. `rsp_rdata` holds its value until the next access is accepted.
- R9: `rsp_done` is high for exactly one cycle, `CLK_DIV`×(7 + dummy + data bytes) cycles after the accepting edge.
- R10: Chip select rises together with `rsp_done` and stays high for one full slot. `busy` is high and `req_ready` is low from acceptance until that slot ends, and requests offered in that time are not taken.
- R11: The memory clock idles low. It toggles only in the middle of opcode, address, dummy and data slots, and it is low again when chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken on this edge |
| req_op | input | 2 | Operation: bit 0 write, bit 1 register |
| req_addr | input | 32 | Access address or register index |
| req_plen | input | log2(MAX_PAIRS) | Array byte pairs minus one |
| req_wdata | input | 16×MAX_PAIRS | Write bytes, byte 0 in the low bits |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | 16×MAX_PAIRS | Read bytes, byte 0 in the low bits |
| busy | output | 1 | Access in progress |
| psram_cs_n | output | 1 | Chip select, active low |
| psram_sck | output | 1 | Memory clock |
| psram_dq_out | output | 8 | Bus output byte |
| psram_dq_oe | output | 1 | Bus output enable |
| psram_dq_in | input | 8 | Bus input byte |

## Verification
The bench builds the engine with `CLK_DIV`=4, so each slot lasts four system clocks. This separates launch, clock edge and sample into different cycles, which makes a misplaced toggle or a sample taken one clock early visible. The default dummy lengths of 18 and 8 and four byte pairs are kept. These settings bring the longest array burst of eight bytes within reach, along with the fixed two-byte register case that ignores the pair count. They also bring both dummy lengths, each fixing a different absolute cycle for `rsp_done`.

// File: rtl/opsram_pkg.sv
package opsram_pkg;

  typedef enum logic [1:0] {
    OP_ARR_RD = 2'b00,
    OP_ARR_WR = 2'b01,
    OP_REG_RD = 2'b10,
    OP_REG_WR = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_TAIL
  } phase_e;

  function automatic logic op_write(op_e op);
    return op[0];
  endfunction

  function automatic logic op_reg(op_e op);
    return op[1];
  endfunction

  // Opcode byte: bit 7 marks a write, bit 6 a register access; sent twice.
  function automatic logic [15:0] op_code(op_e op);
    logic [7:0] b;
    b = {op[0], op[1], 6'b000000};
    return {b, b};
  endfunction

endpackage

// File: rtl/opsram_slot_timer.sv
module opsram_slot_timer #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sck_en,
  output logic slot_end,
  output logic sck
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (cnt_q == CNT_W'(CLK_DIV - 1))
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    sck_d = sck_q;
    if (run && sck_en && (cnt_q == CNT_W'(HALF - 1)))
      sck_d = ~sck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign slot_end = run && (cnt_q == CNT_W'(CLK_DIV - 1));
  assign sck      = sck_q;

  a_r11_sck_mid_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck_q) |-> (cnt_q == CNT_W'(HALF)))
    else $error("memory clock moved outside mid-slot");

endmodule

// File: rtl/opsram_seq.sv
module opsram_seq
  import opsram_pkg::*;
#(
  parameter int RD_DUMMY = 18,
  parameter int WR_DUMMY = 8,
  parameter int PLEN_W   = 2,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              slot_end,
  input  op_e               op_q,
  input  logic [PLEN_W-1:0] plen_q,
  output phase_e            phase,
  output logic [IDX_W-1:0]  idx,
  output logic              done
);
  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  int               len;
  logic             last;

  always_comb begin
    case (phase_q)
      PH_CMD:   len = 2;
      PH_ADDR:  len = 4;
      PH_DUMMY: len = op_write(op_q) ? WR_DUMMY : RD_DUMMY;
      PH_DATA:  len = op_reg(op_q) ? 2 : 2 * (int'(plen_q) + 1);
      default:  len = 1;
    endcase
    last = (int'(idx_q) == len - 1);
  end

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    if (phase_q == PH_IDLE) begin
      idx_d = '0;
      if (req_valid) phase_d = PH_LEAD;
    end else if (slot_end) begin
      if (last) begin
        idx_d = '0;
        case (phase_q)
          PH_LEAD:  phase_d = PH_CMD;
          PH_CMD:   phase_d = PH_ADDR;
          PH_ADDR:  phase_d = PH_DUMMY;
          PH_DUMMY: phase_d = PH_DATA;
          PH_DATA: begin
            phase_d = PH_TAIL;
            done_d  = 1'b1;
          end
          default:  phase_d = PH_IDLE;
        endcase
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  assign phase = phase_q;
  assign idx   = idx_q;
  assign done  = done_q;

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q)
    else $error("done pulse longer than one cycle");

endmodule

// File: rtl/opsram_lane.sv
module opsram_lane
  import opsram_pkg::*;
#(
  parameter int MAX_PAIRS = 4,
  parameter int IDX_W     = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  phase_e                   phase,
  input  logic [IDX_W-1:0]         idx,
  input  op_e                      op_q,
  input  logic [31:0]              addr_q,
  input  logic [16*MAX_PAIRS-1:0]  wdata_q,
  input  logic                     start,
  input  logic                     slot_end,
  input  logic [7:0]               dq_in,
  output logic [7:0]               dq_out,
  output logic                     dq_oe,
  output logic [16*MAX_PAIRS-1:0]  rx
);
  localparam int NBYTES = 2 * MAX_PAIRS;
  localparam int DW     = 8 * NBYTES;

  logic [15:0]   code;
  logic [DW-1:0] rx_q, rx_d;

  always_comb begin
    code   = op_code(op_q);
    dq_out = 8'h00;
    dq_oe  = 1'b0;
    case (phase)
      PH_CMD: begin
        dq_oe  = 1'b1;
        dq_out = (idx == '0) ? code[15:8] : code[7:0];
      end
      PH_ADDR: begin
        dq_oe = 1'b1;
        for (int k = 0; k < 4; k++)
          if (idx == IDX_W'(k)) dq_out = addr_q[8*(3-k) +: 8];
      end
      PH_DUMMY: dq_oe = op_write(op_q);
      PH_DATA: begin
        dq_oe = op_write(op_q);
        if (op_write(op_q))
          for (int k = 0; k < NBYTES; k++)
            if (idx == IDX_W'(k)) dq_out = wdata_q[8*k +: 8];
      end
      default: ;
    endcase
  end

  always_comb begin
    rx_d = rx_q;
    if (start)
      rx_d = '0;
    else if (slot_end && (phase == PH_DATA) && !op_write(op_q))
      for (int k = 0; k < NBYTES; k++)
        if (idx == IDX_W'(k)) rx_d[8*k +: 8] = dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= '0;
    else        rx_q <= rx_d;
  end

  assign rx = rx_q;

  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (phase != PH_DATA)) |=> $stable(rx_q))
    else $error("read data changed outside data phase");

endmodule

// File: rtl/opsram_xact.sv
module opsram_xact
  import opsram_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int RD_DUMMY  = 18,
  parameter int WR_DUMMY  = 8,
  parameter int MAX_PAIRS = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [1:0]                      req_op,
  input  logic [31:0]                     req_addr,
  input  logic [$clog2(MAX_PAIRS)-1:0]    req_plen,
  input  logic [16*MAX_PAIRS-1:0]         req_wdata,
  output logic                            rsp_done,
  output logic [16*MAX_PAIRS-1:0]         rsp_rdata,
  output logic                            busy,
  output logic                            psram_cs_n,
  output logic                            psram_sck,
  output logic [7:0]                      psram_dq_out,
  output logic                            psram_dq_oe,
  input  logic [7:0]                      psram_dq_in
);
  localparam int NBYTES = 2 * MAX_PAIRS;
  localparam int DW     = 8 * NBYTES;
  localparam int PLEN_W = $clog2(MAX_PAIRS);
  localparam int LEN_A  = (RD_DUMMY > WR_DUMMY) ? RD_DUMMY : WR_DUMMY;
  localparam int LEN_B  = (NBYTES > 4) ? NBYTES : 4;
  localparam int MAXLEN = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int IDX_W  = $clog2(MAXLEN);

  // Reset asserts at once and is released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  phase_e             phase;
  logic [IDX_W-1:0]   idx;
  logic               slot_end;
  logic               accept;
  logic               sck_en;
  op_e                op_q;
  logic [31:0]        addr_q;
  logic [PLEN_W-1:0]  plen_q;
  logic [DW-1:0]      wdata_q;

  assign busy      = (phase != PH_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign sck_en    = phase inside {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA};
  assign psram_cs_n = !(phase inside {PH_LEAD, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA});

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      op_q    <= OP_ARR_RD;
      addr_q  <= '0;
      plen_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      op_q    <= op_e'(req_op);
      addr_q  <= req_addr;
      plen_q  <= req_plen;
      wdata_q <= req_wdata;
    end
  end

  opsram_slot_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync),
    .run      (busy),
    .sck_en   (sck_en),
    .slot_end (slot_end),
    .sck      (psram_sck)
  );

  opsram_seq #(
    .RD_DUMMY (RD_DUMMY),
    .WR_DUMMY (WR_DUMMY),
    .PLEN_W   (PLEN_W),
    .IDX_W    (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync),
    .req_valid (req_valid),
    .slot_end  (slot_end),
    .op_q      (op_q),
    .plen_q    (plen_q),
    .phase     (phase),
    .idx       (idx),
    .done      (rsp_done)
  );

  opsram_lane #(
    .MAX_PAIRS (MAX_PAIRS),
    .IDX_W     (IDX_W)
  ) u_lane (
    .clk      (clk),
    .rst_n    (rst_sync),
    .phase    (phase),
    .idx      (idx),
    .op_q     (op_q),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .start    (accept),
    .slot_end (slot_end),
    .dq_in    (psram_dq_in),
    .dq_out   (psram_dq_out),
    .dq_oe    (psram_dq_oe),
    .rx       (rsp_rdata)
  );

  a_r10_cs_rise_with_done: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(psram_cs_n) |-> rsp_done)
    else $error("chip select rose without done");

  a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_sync)
    (req_valid && req_ready) |=> busy)
    else $error("accepted request did not start");

  a_r11_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_sync)
    psram_cs_n |-> !psram_sck)
    else $error("memory clock high while deselected");

endmodule

// File: tb/sim_opsram_xact.sv
module sim_opsram_xact;
  localparam int CD   = 4;
  localparam int HALF = CD / 2;
  localparam int RDD  = 18;
  localparam int WRD  = 8;
  localparam int MP   = 4;
  localparam int DW   = 16 * MP;
  localparam int PW   = $clog2(MP);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready;
  logic [1:0]    req_op;
  logic [31:0]   req_addr;
  logic [PW-1:0] req_plen;
  logic [DW-1:0] req_wdata;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic          busy, psram_cs_n, psram_sck, psram_dq_oe;
  logic [7:0]    psram_dq_out, psram_dq_in;

  opsram_xact #(.CLK_DIV(CD), .RD_DUMMY(RDD), .WR_DUMMY(WRD), .MAX_PAIRS(MP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_plen(req_plen), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .busy(busy),
    .psram_cs_n(psram_cs_n), .psram_sck(psram_sck), .psram_dq_out(psram_dq_out),
    .psram_dq_oe(psram_dq_oe), .psram_dq_in(psram_dq_in)
  );

  int errs = 0;
  int checks = 0;

  logic [7:0]  mem [logic [31:0]];
  logic [15:0] regs [16];

  function automatic logic [7:0] mem_rd(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ 8'h3C;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  // One access, compared against a slot-level model on every clock.
  task automatic xact(input logic [1:0] op, input logic [31:0] addr,
                      input logic [PW-1:0] plen, input logic [DW-1:0] wdata,
                      input bit hold);
    int d, n, S, edges, s, t, j;
    logic prev;
    logic [15:0] cmd;
    logic [DW-1:0] exp_rd;
    logic e_oe;
    logic [7:0] e_dq;
    string tg;
    d = op[0] ? WRD : RDD;
    n = op[1] ? 2 : 2 * (int'(plen) + 1);
    S = 7 + d + n;
    cmd = {op[0], op[1], 6'b0, op[0], op[1], 6'b0};
    exp_rd = '0;
    if (!op[0]) begin
      for (int k = 0; k < n; k++)
        exp_rd[8*k +: 8] = op[1] ? regs[addr[3:0]][8*k +: 8] : mem_rd(addr + 32'(k));
    end else begin
      if (op[1]) regs[addr[3:0]] = wdata[15:0];
      else for (int k = 0; k < n; k++) mem[addr + 32'(k)] = wdata[8*k +: 8];
    end
    chk("R10 ready before request", {63'b0, req_ready}, 64'd1);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_plen = plen; req_wdata = wdata;
    @(posedge clk);
    edges = 0;
    prev = 1'b0;
    for (int k = 0; k <= (S + 1) * CD; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = hold;
        req_op = ~op;
        req_addr = ~addr;
      end
      if (hold && k == S * CD) req_valid = 1'b0;
      s = k / CD;
      t = (k < CD + HALF) ? 0 : (((k - HALF) / CD) < S - 1 ? (k - HALF) / CD : S - 1);
      chk("R10 chip select", {63'b0, psram_cs_n}, {63'b0, !(k < S * CD)});
      chk("R10 busy", {63'b0, busy}, {63'b0, k < (S + 1) * CD});
      chk("R10 ready", {63'b0, req_ready}, {63'b0, !(k < (S + 1) * CD)});
      chk("R9 done timing", {63'b0, rsp_done}, {63'b0, k == S * CD});
      chk("R11 memory clock", {63'b0, psram_sck}, 64'(t % 2));
      e_oe = 1'b0; e_dq = 8'h00; tg = "R5 bus idle";
      if (s == 0 || s >= S) begin
        e_oe = 1'b0;
      end else if (s <= 2) begin
        e_oe = 1'b1; e_dq = (s == 1) ? cmd[15:8] : cmd[7:0]; tg = "R2 opcode";
      end else if (s <= 6) begin
        e_oe = 1'b1; e_dq = addr[8*(6-s) +: 8]; tg = "R3 address";
      end else if (s < 7 + d) begin
        e_oe = op[0]; tg = "R4 R5 dummy";
      end else begin
        j = s - 7 - d;
        e_oe = op[0]; e_dq = wdata[8*j +: 8];
        tg = op[1] ? "R7 register data" : "R6 array data";
      end
      chk(tg, {63'b0, psram_dq_oe}, {63'b0, e_oe});
      if (e_oe) chk(tg, {56'b0, psram_dq_out}, {56'b0, e_dq});
      if (k == S * CD && !op[0]) chk(op[1] ? "R7 R8 register read data" : "R8 read data", rsp_rdata, exp_rd);
      if (psram_sck !== prev) begin
        edges++;
        prev = psram_sck;
        if (!op[0] && (edges - 1) >= 6 + d && (edges - 1) < 6 + d + n)
          psram_dq_in = exp_rd[8*(edges - 1 - 6 - d) +: 8];
      end
    end
    chk("R11 edge count", 64'(edges), 64'(S - 1));
    chk("R8 read data held", rsp_rdata, op[0] ? rsp_rdata : exp_rd);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = {8'h10 + 8'(i), 8'h80 | 8'(i)};
    rst_n = 1'b0;
    req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_plen = '0; req_wdata = '0;
    psram_dq_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset chip select", {63'b0, psram_cs_n}, 64'd1);
    chk("R1 reset clock", {63'b0, psram_sck}, 64'd0);
    chk("R1 reset bus", {63'b0, psram_dq_oe}, 64'd0);
    chk("R1 reset done", {63'b0, rsp_done}, 64'd0);
    chk("R1 reset rdata", rsp_rdata, 64'd0);
    chk("R1 reset ready", {63'b0, req_ready}, 64'd1);

    xact(2'b01, 32'h1234_5678, 2'd3, 64'hF0E1_D2C3_B4A5_9687, 1'b0); // R6 full burst
    xact(2'b00, 32'h1234_5678, 2'd3, 64'h0, 1'b0);                   // R8 readback
    xact(2'b00, 32'h00AB_CDE0, 2'd0, 64'h0, 1'b0);                   // R6 shortest
    xact(2'b11, 32'h0000_0000, 2'd3, 64'hFFFF_FFFF_FFFF_A5C3, 1'b0); // R7 plen ignored
    xact(2'b10, 32'h0000_0000, 2'd2, 64'h0, 1'b0);                   // R7 readback
    xact(2'b10, 32'h0000_0008, 2'd1, 64'h0, 1'b0);                   // R7 index 8
    xact(2'b01, 32'h8000_0100, 2'd1, 64'h0000_0000_1122_3344, 1'b1); // R10 held request
    xact(2'b00, 32'h8000_0100, 2'd1, 64'h0, 1'b1);                   // R8 R10
    repeat (6) @(negedge clk);
    chk("R10 idle after held request", {63'b0, busy}, 64'd0);
    summary();
  end

endmodule